// File: doc/BRIEF.md
# Calibrated Seconds Prescaler with Test Output

This block turns a 32768 Hz oscillator enable into a one-per-second tick. It splits the division into a fine stage of 256 enables and a coarse stage of 128 fine periods. Digital rate correction acts on the fine stage. A control byte holds a 5-bit correction magnitude N and a sign. Over a repeating 64-minute cycle, the first second of each of the first 2×N minutes is trimmed. A positive sign drops one whole fine period, so that second is 256 enables shorter. A negative sign stretches the first fine period by half, so that second is 128 enables longer. Minutes are counted from an external minute strobe, supplied by the time-keeping counters fed by this tick.

The same control byte drives an open-drain pin. In test mode the pin carries a 512 Hz square wave taken from a free-running divider that correction never touches. Otherwise the pin shows a static level bit. A stop input freezes every counter in the block while it is high.

Top module: `cal_prescaler`

## Requirements
- R1: Reset loads the control byte with 0x80 (bit 7 level = 1, bit 6 test mode = 0, sign and magnitude 0). The pin is released (`out_pull_low` = 0), and the first tick comes after 32767 enables, counted from the first enabled edge after reset.
- R2: A second that is not corrected lasts 2^(PRE_W+POST_W) enables (32768 by default), the gap from tick to tick. This holds for magnitude 0 (bits 4:0), whatever the sign bit 5.
- R3: With sign bit 5 = 1 and magnitude N > 0, the corrected second lasts 2^PRE_W enables less than nominal (32512 by default).
- R4: With sign bit 5 = 0 and magnitude N > 0, the corrected second lasts 2^(PRE_W-1) enables more than nominal (32896 by default).
- R5: Only the first second after a minute strobe, or the first second after reset, is corrected. Later seconds in the same minute have nominal length.
- R6: The minute counter is 0 after reset and rises by one per strobe cycle, wrapping from 63 to 0. A minute is corrected only while its count is below 2×N.
- R7: With bit 6 = 1, `out_pull_low` toggles once every 32 enables (512 Hz at 32768 Hz), whatever the magnitude and sign bits hold.
- R8: With bit 6 = 0, `out_pull_low` is the inverse of bit 7.
- R9: While `stop` is high, the second divider, the minute counter's position within the second and the test divider hold. A stopped stretch adds exactly its length in cycles to the second in progress, and the test output does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | One-cycle enable at the oscillator rate |
| stop | input | 1 | Freezes all dividers while high |
| minute_strobe | input | 1 | Advances the 64-minute cycle counter and arms correction |
| ctrl_we | input | 1 | Loads the control byte |
| ctrl_wdata | input | 8 | Control byte: [7] level, [6] test mode, [5] sign, [4:0] magnitude |
| sec_tick | output | 1 | One-cycle pulse on the last enable of each second |
| out_pull_low | output | 1 | Open-drain enable: 1 pulls the pin low |

## Verification
The correction assertions assume that the sign and magnitude bits, and the armed state, do not change part way through a stretched or shortened second. They also assume that minute strobes arrive at second boundaries. The stimulus keeps to this. It writes the control byte and pulses the minute strobe only in the cycles just after a tick. The one exception is a test-mode write made while correction is unarmed. The bench uses a shorter coarse stage (POST_W = 5), so that many complete seconds fit in a short run. The correction amounts do not depend on that parameter.

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int PRE_W  = 8,
  parameter int POST_W = 7,
  parameter int FT_W   = 5,
  parameter int MAG_W  = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_en,
  input  logic       stop,
  input  logic       minute_strobe,
  input  logic       ctrl_we,
  input  logic [7:0] ctrl_wdata,
  output logic       sec_tick,
  output logic       out_pull_low
);
  localparam int LOW_W = PRE_W + 1;
  localparam int MIN_W = MAG_W + 1;
  localparam logic [LOW_W-1:0]  PRE_END    = LOW_W'((1 << PRE_W) - 1);
  localparam logic [LOW_W-1:0]  EXT_END    = LOW_W'((1 << PRE_W) + (1 << (PRE_W - 1)) - 1);
  localparam logic [POST_W-1:0] POST_END   = '1;
  localparam logic [POST_W-1:0] POST_SHORT = POST_END - 1'b1;

  logic [7:0]        ctrl_q;
  logic [LOW_W-1:0]  low_cnt;
  logic [POST_W-1:0] high_cnt;
  logic [MIN_W-1:0]  min_cnt;
  logic              armed;
  logic [FT_W-1:0]   ft_div;
  logic              ft_q;

  wire             lvl     = ctrl_q[7];
  wire             ft_mode = ctrl_q[6];
  wire             cal_pos = ctrl_q[5];
  wire [MAG_W-1:0] mag     = ctrl_q[MAG_W-1:0];
  wire             run     = osc_en & ~stop;

  wire corr_on = armed && (min_cnt < {mag, 1'b0});
  wire [LOW_W-1:0]  low_end  = (corr_on && !cal_pos && high_cnt == '0) ? EXT_END : PRE_END;
  wire [POST_W-1:0] high_end = (corr_on && cal_pos) ? POST_SHORT : POST_END;
  wire pre_wrap = low_cnt >= low_end;
  wire at_end   = pre_wrap && (high_cnt >= high_end);

  assign sec_tick     = run && at_end;
  assign out_pull_low = ft_mode ? ~ft_q : ~lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= 8'h80;
    else if (ctrl_we) ctrl_q <= ctrl_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt  <= '0;
      high_cnt <= '0;
    end else if (run) begin
      if (pre_wrap) begin
        low_cnt  <= '0;
        high_cnt <= at_end ? '0 : high_cnt + 1'b1;
      end else begin
        low_cnt <= low_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      min_cnt <= '0;
      armed   <= 1'b1;
    end else begin
      if (minute_strobe) min_cnt <= min_cnt + 1'b1;
      if (minute_strobe) armed <= 1'b1;
      else if (sec_tick) armed <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ft_div <= '0;
      ft_q   <= 1'b0;
    end else if (run) begin
      ft_div <= ft_div + 1'b1;
      if (ft_div == '1) ft_q <= ~ft_q;
    end
  end

  assert_hold_while_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> $stable(low_cnt) && $stable(high_cnt) && $stable(ft_div));

  assert_tick_restarts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> (low_cnt == '0) && (high_cnt == '0));

  assert_minute_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    minute_strobe |=> min_cnt == $past(min_cnt) + 1'b1);

  assert_ft_half_period_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ft_q) |-> $past(run) && ($past(ft_div) == '1));

  assert_short_second_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && high_cnt != POST_END) |-> (cal_pos && mag != '0 && armed));

  assert_long_fine_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (low_cnt > PRE_END) |-> (!cal_pos && mag != '0 && armed && high_cnt == '0));
endmodule

// File: tb/cal_prescaler_test.sv
module cal_prescaler_test;
  localparam int PRE_W  = 8;
  localparam int POST_W = 5;
  localparam int NOM    = 1 << (PRE_W + POST_W);
  localparam int SHORT  = NOM - (1 << PRE_W);
  localparam int LONG   = NOM + (1 << (PRE_W - 1));

  logic clk = 0, rst_n = 0, osc_en = 0, stop = 0, minute_strobe = 0, ctrl_we = 0;
  logic [7:0] ctrl_wdata = '0;
  logic sec_tick, out_pull_low;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  cal_prescaler #(.PRE_W(PRE_W), .POST_W(POST_W), .FT_W(5), .MAG_W(5)) uut (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .stop(stop),
    .minute_strobe(minute_strobe), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .sec_tick(sec_tick), .out_pull_low(out_pull_low));

  task automatic check(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic run_second(input int nstrobe, input bit wr, input logic [7:0] d,
                            input int exp, input string what);
    int cnt = 0;
    ctrl_we = wr;
    ctrl_wdata = d;
    minute_strobe = (nstrobe > 0);
    do begin
      @(negedge clk);
      cnt++;
      ctrl_we = 0;
      if (cnt >= nstrobe) minute_strobe = 0;
    end while (!sec_tick && cnt < 20000);
    check(cnt, exp, what);
  endtask

  task automatic test_reset();
    int cnt = 0;
    check(out_pull_low, 0, "R1 pin released after reset");
    osc_en = 1;
    do begin
      @(negedge clk);
      cnt++;
      if (cnt == 100) check(out_pull_low, 0, "R1 test mode off after reset");
    end while (!sec_tick && cnt < 20000);
    check(cnt, NOM - 1, "R1 R2 first tick after reset");
  endtask

  task automatic test_correction();
    run_second(2, 1, 8'hA1, NOM, "R6 minute 2 outside window of N=1");
    run_second(1, 1, 8'hA2, SHORT, "R3 positive N=2 minute 3 shortened");
    run_second(0, 0, 8'h00, NOM, "R5 second second of minute nominal");
    run_second(1, 1, 8'h83, LONG, "R4 negative N=3 minute 4 lengthened");
    run_second(60, 1, 8'hA1, SHORT, "R6 wrap to minute 0 corrected");
    run_second(1, 1, 8'hA0, NOM, "R2 magnitude 0 with sign 1 armed");
  endtask

  task automatic test_stop();
    int cnt = 0;
    ctrl_we = 1;
    ctrl_wdata = 8'h80;
    do begin
      @(negedge clk);
      cnt++;
      ctrl_we = 0;
      if (cnt == 100) stop = 1;
      if (cnt == 600) stop = 0;
    end while (!sec_tick && cnt < 20000);
    check(cnt, NOM + 500, "R9 stop stretches second by its length");
  endtask

  task automatic test_level();
    ctrl_we = 1; ctrl_wdata = 8'h00;
    @(negedge clk); ctrl_we = 0;
    check(out_pull_low, 1, "R8 level bit 0 pulls low");
    ctrl_we = 1; ctrl_wdata = 8'h80;
    @(negedge clk); ctrl_we = 0;
    check(out_pull_low, 0, "R8 level bit 1 releases");
  endtask

  task automatic test_ft();
    logic prev;
    int cnt;
    ctrl_we = 1; ctrl_wdata = 8'h7F;
    @(negedge clk); ctrl_we = 0;
    prev = out_pull_low;
    cnt = 0;
    while (out_pull_low == prev && cnt < 100) begin @(negedge clk); cnt++; end
    for (int k = 0; k < 2; k++) begin
      prev = out_pull_low;
      cnt = 0;
      while (out_pull_low == prev && cnt < 100) begin @(negedge clk); cnt++; end
      check(cnt, 32, "R7 test output half period");
    end
    stop = 1;
    prev = out_pull_low;
    cnt = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (out_pull_low != prev || sec_tick) cnt++;
    end
    stop = 0;
    check(cnt, 0, "R9 test output and tick frozen while stopped");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    test_reset();
    test_correction();
    test_stop();
    test_level();
    test_ft();
    finish_run();
  end
endmodule